// File: doc/BRIEF.md
# BCD Sixes-Generation Execute Unit

This execution unit serves a decimal-assist instruction. It accepts an instruction word and two 64-bit operands. The operands are taken as sixteen packed 4-bit digits, with digit 0 the least significant. The unit adds the operands as plain binary numbers and notes whether each digit position produced a carry. The result is a 64-bit correction word. Each digit of that word is 6 when its position produced no carry and 0 when it did. Later decimal arithmetic subtracts this word to turn a binary sum back into valid BCD. The carry out of the top digit is not reported on its own.

A small decoder checks the instruction word. When the word matches and the decimal-assist enable is high, the unit returns the correction word together with the three register indices from the word. The result sits in a register behind a valid/ready handshake. A word that does not match, or any request made while the enable is low, produces a one-cycle illegal flag and no result.

Top module: `bcd_sixes_unit`

## Requirements
- R1: Each digit of the result is 4'h6 when that digit position produced no carry-out and 4'h0 when it did. The carry-out comes from the operand nibbles plus the carry-in.
- R2: Carries ripple from digit to digit as in a full 64-bit binary add. Digit i+1 takes the carry-out of digit i as its carry-in, and digit 0 has a carry-in of zero.
- R3: A word is recognised when insn[31:26] = 6'b011111 and insn[9:1] = 9'b001001010. The values of insn[10] and insn[0] have no effect.
- R4: The result carries its register indices: res_rt = insn[25:21], res_ra = insn[20:16] and res_rb = insn[15:11].
- R5: When feat_en is low, an accepted request sets illegal for exactly one cycle and does not raise res_valid.
- R6: An accepted request whose word is not recognised sets illegal for exactly one cycle and does not raise res_valid.
- R7: res_valid rises in the cycle after a legal request is accepted. While res_ready is low it stays high, and res_data and the indices stay unchanged.
- R8: req_ready equals (!res_valid || res_ready). A request is accepted only when req_valid and req_ready are both high.
- R9: A synchronous active-high reset clears both res_valid and illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Decimal-assist feature enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| insn | input | 32 | Instruction word |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| res_valid | output | 1 | Result held and valid |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 64 | Correction word |
| res_rt | output | 5 | Destination register index |
| res_ra | output | 5 | First source register index |
| res_rb | output | 5 | Second source register index |
| illegal | output | 1 | One-cycle pulse for an illegal request |

## Verification
The assertions assume that the consumer does not change res_ready between clock edges. They also assume that, after reset, req_valid and feat_en are always 0 or 1 and never unknown. The bench drives every input on the falling edge and keeps each input at a known level throughout. It lowers req_valid straight after each accepted request. As a result, illegal pulses and results never overlap in ways the properties do not cover. The back-pressure test holds res_ready low across several edges so that the hold property is exercised.

// File: rtl/bcd_sixes_unit.sv
module bcd_sixes_unit #(
  parameter int DIGITS = 16,
  parameter logic [5:0] PRIMARY = 6'b011111,
  parameter logic [8:0] EXT_OP = 9'b001001010
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  feat_en,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [31:0]           insn,
  input  logic [4*DIGITS-1:0]   opnd_a,
  input  logic [4*DIGITS-1:0]   opnd_b,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [4*DIGITS-1:0]   res_data,
  output logic [4:0]            res_rt,
  output logic [4:0]            res_ra,
  output logic [4:0]            res_rb,
  output logic                  illegal
);
  localparam int W = 4 * DIGITS;

  logic [DIGITS:0] cy;
  logic [W-1:0]    sixes;
  logic            match, legal, accept;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [4:0] dsum;
    assign dsum = {1'b0, opnd_a[4*i +: 4]} + {1'b0, opnd_b[4*i +: 4]} + {4'd0, cy[i]};
    assign cy[i+1] = dsum[4];
    assign sixes[4*i +: 4] = cy[i+1] ? 4'h0 : 4'h6;
  end

  assign match     = (insn[31:26] == PRIMARY) && (insn[9:1] == EXT_OP);
  assign legal     = match && feat_en;
  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      illegal   <= 1'b0;
      res_data  <= '0;
      res_rt    <= '0;
      res_ra    <= '0;
      res_rb    <= '0;
    end else begin
      illegal <= accept && !legal;
      if (accept) begin
        res_valid <= legal;
        if (legal) begin
          res_data <= sixes;
          res_rt   <= insn[25:21];
          res_ra   <= insn[20:16];
          res_rb   <= insn[15:11];
        end
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  localparam logic [W-1:0] LOW_MASK = {DIGITS{4'b1001}};
  localparam logic [W-1:0] BIT1     = {DIGITS{4'b0010}};

  p_digit_form_r1: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((res_data & LOW_MASK) == '0) &&
                  (((res_data & BIT1) << 1) == (res_data & (BIT1 << 1))));

  p_top_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && legal && ({1'b0, opnd_a} + {1'b0, opnd_b}) < (65'd1 << (W-4)))
      |=> res_data[W-1 -: 4] == 4'h6);

  p_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && !feat_en) |=> (illegal && !res_valid));

  p_nomatch_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && !match) |=> (illegal && !res_valid));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_rt)));

  p_backpressure_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |-> !req_ready);

  p_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid && !illegal));
endmodule

// File: tb/tb_bcd_sixes_unit.sv
module tb_bcd_sixes_unit;
  logic clk = 0, rst = 1, feat_en = 1, req_valid = 0, res_ready = 1;
  logic [31:0] insn = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic req_ready, res_valid, illegal;
  logic [63:0] res_data;
  logic [4:0] res_rt, res_ra, res_rb;
  int errors = 0, checks = 0, cyc = 0;

  always #5 clk = ~clk;

  bcd_sixes_unit dut (.clk, .rst, .feat_en, .req_valid, .req_ready, .insn,
    .opnd_a, .opnd_b, .res_valid, .res_ready, .res_data, .res_rt, .res_ra,
    .res_rb, .illegal);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam int NV = 8;
  localparam logic [191:0] VEC [NV] = '{
    {64'h0, 64'h0, 64'h6666666666666666},
    {64'h9999999999999999, 64'h9999999999999999, 64'h0},
    {64'h00000000FFFFFFFF, 64'h1, 64'h6666666600000000},
    {64'hFFFFFFFFFFFFFFFF, 64'h0, 64'h6666666666666666},
    {64'hFFFFFFFFFFFFFFFF, 64'h1, 64'h0},
    {64'h8000000000000000, 64'h8000000000000000, 64'h0666666666666666},
    {64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h6666666666666666},
    {64'h5, 64'hB, 64'h6666666666666660}
  };

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b);
    logic c = 0;
    logic [4:0] s;
    model = '0;
    for (int i = 0; i < 16; i++) begin
      s = a[4*i +: 4] + b[4*i +: 4] + c;
      c = s[4];
      model[4*i +: 4] = c ? 4'h0 : 4'h6;
    end
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] rt, ra, rb, input logic x10, x0);
    mk = {6'b011111, rt, ra, rb, x10, 9'b001001010, x0};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] a, b);
    @(negedge clk);
    insn = w; opnd_a = a; opnd_b = b; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    logic [63:0] ra, rb, hold;
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {63'd0, res_valid}, 64'd0);
    chk("R9 reset illegal", {63'd0, illegal}, 64'd0);
    chk("R8 ready idle", {63'd0, req_ready}, 64'd1);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      issue(mk(5'd3, 5'd4, 5'd5, 0, 0), VEC[i][191:128], VEC[i][127:64]);
      chk("R7 valid", {63'd0, res_valid}, 64'd1);
      chk("R1 R2 vector", res_data, VEC[i][63:0]);
      chk("R1 model", res_data, model(VEC[i][191:128], VEC[i][127:64]));
    end

    ra = 64'h0123456789ABCDEF; rb = 64'h0F1E2D3C4B5A6978;
    for (int i = 0; i < 20; i++) begin
      ra = {ra[62:0], ra[63] ^ ra[62] ^ ra[60] ^ ra[59]};
      rb = rb * 64'd6364136223846793005 + 64'd1442695040888963407;
      issue(mk(5'd1, 5'd2, 5'd7, 0, 0), ra, rb);
      chk("R2 random", res_data, model(ra, rb));
    end

    issue(mk(5'd31, 5'd17, 5'd9, 1, 1), 64'h0, 64'h0);
    chk("R3 ignored bits", {63'd0, res_valid}, 64'd1);
    chk("R4 rt", {59'd0, res_rt}, 64'd31);
    chk("R4 ra", {59'd0, res_ra}, 64'd17);
    chk("R4 rb", {59'd0, res_rb}, 64'd9);

    feat_en = 0;
    issue(mk(5'd1, 5'd1, 5'd1, 0, 0), 64'h0, 64'h0);
    chk("R5 illegal", {63'd0, illegal}, 64'd1);
    chk("R5 no result", {63'd0, res_valid}, 64'd0);
    @(negedge clk);
    chk("R5 one cycle", {63'd0, illegal}, 64'd0);
    feat_en = 1;

    issue(mk(5'd1, 5'd1, 5'd1, 0, 0) ^ 32'h0000_0002, 64'h0, 64'h0);
    chk("R6 bad xo illegal", {63'd0, illegal}, 64'd1);
    chk("R6 bad xo no result", {63'd0, res_valid}, 64'd0);
    issue(mk(5'd1, 5'd1, 5'd1, 0, 0) ^ 32'h0400_0000, 64'h0, 64'h0);
    chk("R6 bad primary", {63'd0, illegal}, 64'd1);
    @(negedge clk);
    chk("R6 one cycle", {63'd0, illegal}, 64'd0);

    res_ready = 0;
    issue(mk(5'd2, 5'd2, 5'd2, 0, 0), 64'h5, 64'hB);
    hold = res_data;
    chk("R8 stall ready", {63'd0, req_ready}, 64'd0);
    issue(mk(5'd2, 5'd2, 5'd2, 0, 0), 64'h0, 64'h0);
    @(negedge clk);
    chk("R7 held valid", {63'd0, res_valid}, 64'd1);
    chk("R7 held data", res_data, hold);
    chk("R8 ignored req", res_data, 64'h6666666666666660);
    res_ready = 1;
    @(negedge clk);
    chk("R7 consumed", {63'd0, res_valid}, 64'd0);

    issue(mk(5'd2, 5'd2, 5'd2, 0, 0), 64'h0, 64'h0);
    rst = 1;
    @(negedge clk);
    chk("R9 sync reset", {63'd0, res_valid}, 64'd0);
    rst = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule